// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block owns the fetch address register of a 32-bit fetch stage whose architecture has one delay slot after every control transfer. Each time the stage advances, the unit is told what kind of control transfer, if any, the instruction at the current fetch address is. It is also given that instruction's immediate field and the register values needed to resolve it. From these it works out the following fetch address, the value to write into the link register, and whether the next instruction is to be annulled.

A control transfer never redirects fetch at once. The instruction right after it, the delay slot, is always fetched next. The resolved target is held in a register and takes effect on the step that leaves the slot. Branch offsets count instructions from the delay-slot address. The "likely" form of a conditional branch cancels its slot when the branch falls through; the unit flags that slot with an annul output and leaves the discarding to the execute side. A control kind presented while the fetch address is a delay slot is not acted on. Reset release is expected to arrive already synchronised to `clk_i`.

Kind codes on `xfer_kind_i`:
- 0: none
- 1: equal
- 2: not equal
- 3: a>=0
- 4: a>0
- 5: a<=0
- 6: a<0
- 7: a>=0 with link
- 8: a<0 with link
- 9: absolute jump
- 10: absolute jump with link
- 11: register jump
- 12: register jump with link
- 13 to 15: treated as none

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, and after release until the first enabled step, `fetch_pc_o` equals the parameter `RESET_PC` (default 0xBFC00000), and `dslot_o`, `slot_annul_o` and `link_we_o` are 0.
- R2: A clock edge with `step_en_i` low changes neither `fetch_pc_o`, `dslot_o`, `slot_annul_o` nor a pending redirect.
- R3: An enabled step with kind 0 (or 13 to 15) outside a delay slot advances `fetch_pc_o` by 4 and leaves `dslot_o` at 0.
- R4: An enabled step with any kind from 1 to 12 outside a delay slot moves `fetch_pc_o` to P+4, where P is the address of the transfer, and sets `dslot_o` to 1.
- R5: For kinds 1 to 8, the target is P+4 plus the sign-extended `imm_field_i[15:0]` times 4. Offsets 0x7FFF and 0x8000 give the extreme forward and backward reach, with 32-bit wrap.
- R6: The conditions are: kind 1 a==b, kind 2 a!=b, kinds 3 and 7 a>=0, kind 4 a>0, kind 5 a<=0, kinds 6 and 8 a<0. Here a and b are two's-complement values. The step that leaves the slot loads the target if the condition held, and P+8 otherwise.
- R7: `slot_annul_o` is 1 for the whole slot cycle only when `likely_i` was 1 on a conditional kind (1 to 8) whose condition failed. A taken likely branch, a non-likely branch and a jump with `likely_i` set leave it at 0.
- R8: Kinds 9 and 10 always transfer to {P+4 bits 31:28, `imm_field_i[25:0]`, 2'b00} after the slot.
- R9: Kinds 11 and 12 always transfer to `opnd_a_i` as sampled at the transfer, after the slot.
- R10: During the enabled step of kinds 7, 8 and 10, `link_we_o` is 1 with `link_idx_o`=31; for kind 12 it is 1 with `link_idx_o`=`link_dest_i`. In both cases `link_val_o`=P+8, whether or not the branch is taken. For every other kind, `link_we_o` is 0.
- R11: In a delay slot, whether annulled or not, the kind input is ignored. There is no link write and no new redirect, and the step out of the slot goes to the pending target or to slot address+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_en_i | input | 1 | Fetch advance enable |
| xfer_kind_i | input | 4 | Control-transfer kind of the instruction at `fetch_pc_o` |
| likely_i | input | 1 | Annul-slot-when-not-taken variant |
| imm_field_i | input | 26 | Jump index; low 16 bits are the branch offset |
| opnd_a_i | input | 32 | First condition operand and register jump target |
| opnd_b_i | input | 32 | Second condition operand |
| link_dest_i | input | 5 | Link register index for the register jump with link |
| fetch_pc_o | output | 32 | Current fetch address |
| dslot_o | output | 1 | Current fetch address is a delay slot |
| slot_annul_o | output | 1 | Current delay-slot instruction is annulled |
| link_we_o | output | 1 | Link write request in this step |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value (transfer address + 8) |

## Verification
The hardest situation to reach is a control kind arriving while the unit is already inside a delay slot. This is the moment where a second redirect or link write could corrupt the pending one, and it is hardest of all in an annulled slot or one held by a stalled step. The stimulus places a taken branch and then drives a linked jump into its slot. It also drives an absolute jump into the annulled slot of a failed likely branch. Finally it holds `step_en_i` low inside a slot before leaving it, and confirms that only the first transfer's target or fall-through address appears.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    XK_NONE     = 4'd0,
    XK_EQ       = 4'd1,
    XK_NE       = 4'd2,
    XK_GE0      = 4'd3,
    XK_GT0      = 4'd4,
    XK_LE0      = 4'd5,
    XK_LT0      = 4'd6,
    XK_GE0_LINK = 4'd7,
    XK_LT0_LINK = 4'd8,
    XK_ABS      = 4'd9,
    XK_ABS_LINK = 4'd10,
    XK_REG      = 4'd11,
    XK_REG_LINK = 4'd12
  } xfer_kind_e;

  localparam int unsigned KIND_W = 4;

  // conditional branch forms (offset-relative target)
  function automatic logic kind_is_cond(input logic [KIND_W-1:0] k);
    return (k >= XK_EQ) && (k <= XK_LT0_LINK);
  endfunction

  // any control transfer that opens a delay slot
  function automatic logic kind_is_ctrl(input logic [KIND_W-1:0] k);
    return (k >= XK_EQ) && (k <= XK_REG_LINK);
  endfunction

  function automatic logic kind_is_link(input logic [KIND_W-1:0] k);
    return (k == XK_GE0_LINK) || (k == XK_LT0_LINK) ||
           (k == XK_ABS_LINK) || (k == XK_REG_LINK);
  endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic              taken_o
);

  logic a_neg;
  logic a_zero;
  logic a_eq_b;

  assign a_neg  = opa_i[XLEN-1];
  assign a_zero = (opa_i == '0);
  assign a_eq_b = (opa_i == opb_i);

  always_comb begin
    unique case (kind_i)
      XK_EQ:                   taken_o = a_eq_b;
      XK_NE:                   taken_o = ~a_eq_b;
      XK_GE0, XK_GE0_LINK:     taken_o = ~a_neg;
      XK_GT0:                  taken_o = ~a_neg & ~a_zero;
      XK_LE0:                  taken_o = a_neg | a_zero;
      XK_LT0, XK_LT0_LINK:     taken_o = a_neg;
      XK_ABS, XK_ABS_LINK,
      XK_REG, XK_REG_LINK:     taken_o = 1'b1;
      default:                 taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [JIDX_W-1:0] imm_i,
  input  logic [XLEN-1:0]   reg_tgt_i,
  output logic [XLEN-1:0]   seq_pc_o,
  output logic [XLEN-1:0]   link_pc_o,
  output logic [XLEN-1:0]   tgt_o
);

  localparam int unsigned EXT_W  = XLEN - OFF_W - 2;
  localparam int unsigned REGN_W = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] off_bytes;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;

  assign seq_pc_o  = pc_i + XLEN'(4);
  assign link_pc_o = pc_i + XLEN'(8);

  // instruction-count offset scaled to bytes, sign-extended
  assign off_bytes = {{EXT_W{imm_i[OFF_W-1]}}, imm_i[OFF_W-1:0], 2'b00};
  assign rel_tgt   = seq_pc_o + off_bytes;

  // region bits come from the delay-slot address
  assign abs_tgt   = {seq_pc_o[XLEN-1 -: REGN_W], imm_i, 2'b00};

  always_comb begin
    if ((kind_i == XK_REG) || (kind_i == XK_REG_LINK)) begin
      tgt_o = reg_tgt_i;
    end else if ((kind_i == XK_ABS) || (kind_i == XK_ABS_LINK)) begin
      tgt_o = abs_tgt;
    end else begin
      tgt_o = rel_tgt;
    end
  end

endmodule

// File: rtl/npc_seq.sv
module npc_seq #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'hBFC0_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_en_i,
  input  logic            open_slot_i,
  input  logic            taken_i,
  input  logic            annul_req_i,
  input  logic [XLEN-1:0] tgt_i,
  input  logic [XLEN-1:0] seq_pc_i,
  output logic [XLEN-1:0] pc_o,
  output logic            slot_o,
  output logic            annul_o
);

  logic [XLEN-1:0] pc_q,   pc_d;
  logic [XLEN-1:0] tgt_q,  tgt_d;
  logic            slot_q, slot_d;
  logic            pend_q, pend_d;
  logic            annul_q, annul_d;
  logic            tgt_en;

  // next-state logic
  always_comb begin
    pc_d    = seq_pc_i;
    slot_d  = 1'b0;
    pend_d  = 1'b0;
    annul_d = 1'b0;
    tgt_d   = tgt_q;
    tgt_en  = 1'b0;
    if (slot_q) begin
      if (pend_q) begin
        pc_d = tgt_q;
      end
    end else if (open_slot_i) begin
      slot_d  = 1'b1;
      pend_d  = taken_i;
      annul_d = annul_req_i;
      tgt_d   = tgt_i;
      tgt_en  = taken_i;
    end
  end

  // state registers with explicit clock enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      slot_q  <= 1'b0;
      pend_q  <= 1'b0;
      annul_q <= 1'b0;
    end else if (step_en_i) begin
      pc_q    <= pc_d;
      slot_q  <= slot_d;
      pend_q  <= pend_d;
      annul_q <= annul_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else if (step_en_i && tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  assign pc_o    = pc_q;
  assign slot_o  = slot_q;
  assign annul_o = annul_q;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     OFF_W     = 16,
  parameter int unsigned     JIDX_W    = 26,
  parameter int unsigned     RIDX_W    = 5,
  parameter logic [XLEN-1:0] RESET_PC  = 32'hBFC0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic [3:0]        xfer_kind_i,
  input  logic              likely_i,
  input  logic [JIDX_W-1:0] imm_field_i,
  input  logic [XLEN-1:0]   opnd_a_i,
  input  logic [XLEN-1:0]   opnd_b_i,
  input  logic [RIDX_W-1:0] link_dest_i,
  output logic [XLEN-1:0]   fetch_pc_o,
  output logic              dslot_o,
  output logic              slot_annul_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o
);

  localparam logic [RIDX_W-1:0] LINK_REG = {RIDX_W{1'b1}};

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] link_pc;
  logic [XLEN-1:0] tgt;
  logic            in_slot;
  logic            taken;
  logic            open_slot;
  logic            annul_req;

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (xfer_kind_i),
    .opa_i   (opnd_a_i),
    .opb_i   (opnd_b_i),
    .taken_o (taken)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_i      (pc),
    .kind_i    (xfer_kind_i),
    .imm_i     (imm_field_i),
    .reg_tgt_i (opnd_a_i),
    .seq_pc_o  (seq_pc),
    .link_pc_o (link_pc),
    .tgt_o     (tgt)
  );

  // a transfer is only honoured outside a delay slot
  assign open_slot = kind_is_ctrl(xfer_kind_i) & ~in_slot;
  assign annul_req = likely_i & kind_is_cond(xfer_kind_i) & ~taken;

  npc_seq #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_en_i   (step_en_i),
    .open_slot_i (open_slot),
    .taken_i     (taken),
    .annul_req_i (annul_req),
    .tgt_i       (tgt),
    .seq_pc_i    (seq_pc),
    .pc_o        (pc),
    .slot_o      (in_slot),
    .annul_o     (slot_annul_o)
  );

  assign fetch_pc_o = pc;
  assign dslot_o    = in_slot;
  assign link_we_o  = step_en_i & ~in_slot & kind_is_link(xfer_kind_i);
  assign link_idx_o = (xfer_kind_i == XK_REG_LINK) ? link_dest_i : LINK_REG;
  assign link_val_o = link_pc;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_en_i,
  input logic [3:0]        xfer_kind_i,
  input logic [XLEN-1:0]   fetch_pc_o,
  input logic              dslot_o,
  input logic              slot_annul_o,
  input logic              link_we_o,
  input logic [RIDX_W-1:0] link_idx_o
);

  AST_HOLD_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> $stable(fetch_pc_o) && $stable(dslot_o)); // R2

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && !dslot_o && !kind_is_ctrl(xfer_kind_i)
    |=> (fetch_pc_o == $past(fetch_pc_o) + XLEN'(4)) && !dslot_o); // R3

  AST_SLOT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && !dslot_o && kind_is_ctrl(xfer_kind_i)
    |=> (fetch_pc_o == $past(fetch_pc_o) + XLEN'(4)) && dslot_o); // R4

  AST_ANNUL_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_annul_o |-> dslot_o); // R7

  AST_LINK_NOT_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> !dslot_o && step_en_i); // R10

  AST_LINK_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o && (xfer_kind_i != XK_REG_LINK) |-> link_idx_o == '1); // R10

  AST_SLOT_LEAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && dslot_o |=> !dslot_o && !slot_annul_o); // R11

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_en_i    (step_en_i),
  .xfer_kind_i  (xfer_kind_i),
  .fetch_pc_o   (fetch_pc_o),
  .dslot_o      (dslot_o),
  .slot_annul_o (slot_annul_o),
  .link_we_o    (link_we_o),
  .link_idx_o   (link_idx_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;

  localparam logic [31:0] RST_PC = 32'hBFC0_0000;

  typedef struct packed {
    logic [3:0]  kind;
    logic        likely;
    logic [25:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  rd;
    logic        taken;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b0, 26'h0003,    32'd5,          32'd5, 5'd0, 1'b1},
    '{4'd1,  1'b0, 26'h0003,    32'd5,          32'd6, 5'd0, 1'b0},
    '{4'd2,  1'b0, 26'hFFFE,    32'd5,          32'd6, 5'd0, 1'b1},
    '{4'd2,  1'b0, 26'h0010,    32'd7,          32'd7, 5'd0, 1'b0},
    '{4'd3,  1'b0, 26'h0020,    32'd0,          32'd0, 5'd0, 1'b1},
    '{4'd3,  1'b0, 26'h0020,    32'h8000_0000,  32'd0, 5'd0, 1'b0},
    '{4'd4,  1'b0, 26'h0004,    32'd0,          32'd0, 5'd0, 1'b0},
    '{4'd4,  1'b0, 26'h7FFF,    32'd1,          32'd0, 5'd0, 1'b1},
    '{4'd5,  1'b0, 26'h8000,    32'd0,          32'd0, 5'd0, 1'b1},
    '{4'd5,  1'b0, 26'h0008,    32'd1,          32'd0, 5'd0, 1'b0},
    '{4'd6,  1'b0, 26'h0011,    32'hFFFF_FFFF,  32'd0, 5'd0, 1'b1},
    '{4'd6,  1'b0, 26'h0011,    32'd0,          32'd0, 5'd0, 1'b0},
    '{4'd1,  1'b1, 26'h0005,    32'd1,          32'd2, 5'd0, 1'b0},
    '{4'd2,  1'b1, 26'h0005,    32'd1,          32'd2, 5'd0, 1'b1},
    '{4'd7,  1'b0, 26'h0006,    32'hFFFF_FFFF,  32'd0, 5'd0, 1'b0},
    '{4'd8,  1'b0, 26'h0006,    32'hFFFF_FFFF,  32'd0, 5'd0, 1'b1},
    '{4'd9,  1'b0, 26'h0123456, 32'd0,          32'd0, 5'd0, 1'b1},
    '{4'd10, 1'b0, 26'h3FFFFFF, 32'd0,          32'd0, 5'd0, 1'b1},
    '{4'd11, 1'b0, 26'h0000,    32'h0040_0020,  32'd0, 5'd0, 1'b1},
    '{4'd12, 1'b0, 26'h0000,    32'h8000_1234,  32'd0, 5'd9, 1'b1},
    '{4'd9,  1'b1, 26'h0000040, 32'd0,          32'd0, 5'd0, 1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        step_en_i;
  logic [3:0]  xfer_kind_i;
  logic        likely_i;
  logic [25:0] imm_field_i;
  logic [31:0] opnd_a_i;
  logic [31:0] opnd_b_i;
  logic [4:0]  link_dest_i;
  logic [31:0] fetch_pc_o;
  logic        dslot_o;
  logic        slot_annul_o;
  logic        link_we_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_val_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  npc_unit #(.RESET_PC(RST_PC)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_en_i    (step_en_i),
    .xfer_kind_i  (xfer_kind_i),
    .likely_i     (likely_i),
    .imm_field_i  (imm_field_i),
    .opnd_a_i     (opnd_a_i),
    .opnd_b_i     (opnd_b_i),
    .link_dest_i  (link_dest_i),
    .fetch_pc_o   (fetch_pc_o),
    .dslot_o      (dslot_o),
    .slot_annul_o (slot_annul_o),
    .link_we_o    (link_we_o),
    .link_idx_o   (link_idx_o),
    .link_val_o   (link_val_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] k, input logic lk, input logic [25:0] im,
                       input logic [31:0] a, input logic [31:0] b, input logic [4:0] rd);
    xfer_kind_i = k; likely_i = lk; imm_field_i = im;
    opnd_a_i = a; opnd_b_i = b; link_dest_i = rd;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [31:0] exp_target(input vec_t v, input logic [31:0] p);
    logic [31:0] s4;
    s4 = p + 32'd4;
    if (v.kind == 4'd9 || v.kind == 4'd10) return {s4[31:28], v.imm, 2'b00};
    if (v.kind == 4'd11 || v.kind == 4'd12) return v.a;
    return s4 + {{14{v.imm[15]}}, v.imm[15:0], 2'b00};
  endfunction

  task automatic run_vec(input vec_t v);
    logic [31:0] p;
    logic        is_cond;
    logic        lnk;
    logic [4:0]  lidx;
    string       ttag;
    p       = fetch_pc_o;
    is_cond = (v.kind >= 4'd1) && (v.kind <= 4'd8);
    lnk     = (v.kind == 4'd7) || (v.kind == 4'd8) || (v.kind == 4'd10) || (v.kind == 4'd12);
    lidx    = (v.kind == 4'd12) ? v.rd : 5'd31;
    ttag    = is_cond ? "R5 R6 branch destination" :
              ((v.kind >= 4'd11) ? "R9 register jump" : "R8 absolute jump");
    drive(v.kind, v.likely, v.imm, v.a, v.b, v.rd);
    step_en_i = 1'b1;
    #1;
    chk("R10 link write", {31'd0, link_we_o}, {31'd0, lnk});
    if (lnk) begin
      chk("R10 link value", link_val_o, p + 32'd8);
      chk("R10 link index", {27'd0, link_idx_o}, {27'd0, lidx});
    end
    tick();
    chk("R4 slot address", fetch_pc_o, p + 32'd4);
    chk("R4 slot flag", {31'd0, dslot_o}, 32'd1);
    chk("R7 annul", {31'd0, slot_annul_o}, {31'd0, is_cond & v.likely & ~v.taken});
    drive(4'd0, 1'b0, 26'd0, 32'd0, 32'd0, 5'd0);
    tick();
    chk(ttag, fetch_pc_o, v.taken ? exp_target(v, p) : p + 32'd8);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] p;
    rst_ni = 1'b0;
    step_en_i = 1'b0;
    drive(4'd0, 1'b0, 26'd0, 32'd0, 32'd0, 5'd0);
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset pc", fetch_pc_o, RST_PC);
    chk("R1 reset slot", {31'd0, dslot_o}, 32'd0);
    chk("R1 reset annul", {31'd0, slot_annul_o}, 32'd0);
    rst_ni = 1'b1;
    tick();
    chk("R1 pc after release", fetch_pc_o, RST_PC);
    chk("R1 link idle", {31'd0, link_we_o}, 32'd0);

    // R2: stepping held off with a taken branch presented
    drive(4'd1, 1'b0, 26'h10, 32'd3, 32'd3, 5'd0);
    tick(); tick();
    chk("R2 hold pc", fetch_pc_o, RST_PC);
    chk("R2 hold slot", {31'd0, dslot_o}, 32'd0);

    // R3: plain sequential steps, including an unused kind code
    drive(4'd0, 1'b0, 26'd0, 32'd0, 32'd0, 5'd0);
    step_en_i = 1'b1;
    tick();
    chk("R3 sequential", fetch_pc_o, RST_PC + 32'd4);
    drive(4'd14, 1'b1, 26'h55, 32'd0, 32'd0, 5'd0);
    tick();
    chk("R3 unused kind sequential", fetch_pc_o, RST_PC + 32'd8);
    chk("R3 unused kind no slot", {31'd0, dslot_o}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: linked jump presented inside a taken branch's slot
    p = fetch_pc_o;
    drive(4'd1, 1'b0, 26'h0010, 32'd9, 32'd9, 5'd0);
    tick();
    drive(4'd10, 1'b0, 26'h0000100, 32'd0, 32'd0, 5'd0);
    #1;
    chk("R11 no link in slot", {31'd0, link_we_o}, 32'd0);
    tick();
    chk("R11 first target kept", fetch_pc_o, p + 32'd4 + 32'h40);

    // R11: jump presented inside an annulled slot
    p = fetch_pc_o;
    drive(4'd2, 1'b1, 26'h0010, 32'd4, 32'd4, 5'd0);
    tick();
    chk("R11 R7 annulled slot", {31'd0, slot_annul_o}, 32'd1);
    drive(4'd9, 1'b0, 26'h0000200, 32'd0, 32'd0, 5'd0);
    tick();
    chk("R11 annulled slot ignores jump", fetch_pc_o, p + 32'd8);

    // R2: stall inside a slot keeps the pending redirect
    p = fetch_pc_o;
    drive(4'd11, 1'b0, 26'd0, 32'h1000_0040, 32'd0, 5'd0);
    tick();
    step_en_i = 1'b0;
    drive(4'd0, 1'b0, 26'd0, 32'd0, 32'd0, 5'd0);
    tick(); tick();
    chk("R2 slot held pc", fetch_pc_o, p + 32'd4);
    chk("R2 slot held flag", {31'd0, dslot_o}, 32'd1);
    step_en_i = 1'b1;
    tick();
    chk("R2 R9 pending target after stall", fetch_pc_o, 32'h1000_0040);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule